// File: doc/BRIEF.md
# Narrow-Load Extend and Byte-Swap Unit

This unit forms the register writeback value for a 32-bit core in two situations. For a narrow load it picks the byte or halfword out of a fetched little-endian word and widens it to 32 bits. For the register-to-register widen and byte-swap operations it transforms a register operand directly. Memory access, alignment faults and condition flags are handled elsewhere.

The caller presents an operand, a two-bit byte-lane offset and a four-bit operation code. The result appears on `result_o` one clock later. A synchronous active-low reset clears the result register.

Operation codes:
- 0 to 7: the extend group. Bit 2 of the code is 0 for a load, which picks from the lane given by the offset, and 1 for a register extend, which uses the low bits of the operand. Bit 1 of the code is 1 for halfword size and 0 for byte size. Bit 0 of the code is 1 for signed and 0 for unsigned.
- 8: full swap.
- 9: swap within each half.
- 10: signed low-half swap.
- 11 to 15: pass-through.

Top module: `ldx_unit`

## Requirements
- R1: For the unsigned codes 0, 2, 4 and 6, the bits above the selected byte or halfword are zero. For example, the byte 0x80 gives 0x0000_0080.
- R2: For the signed codes 1, 3, 5 and 7, every bit above the selected byte or halfword copies its top bit. For example, the byte 0x80 gives 0xFFFF_FF80.
- R3: The load codes 0 to 3 take byte lane n from operand bits [8n+7:8n], so lane 0 is the least significant byte. The load codes 0 to 3 take the halfword from bits [15:0] when offset bit 1 is 0 and from bits [31:16] when it is 1.
- R4: Halfword loads (codes 2 and 3) ignore offset bit 0, so odd offsets 1 and 3 give the same result as offsets 0 and 2.
- R5: The register extend codes 4 to 7 always use operand bits [7:0] or [15:0] and ignore the offset.
- R6: Code 8 places operand byte 3 in result byte 0, byte 2 in byte 1, byte 1 in byte 2 and byte 0 in byte 3.
- R7: Code 9 exchanges byte 0 with byte 1 and byte 2 with byte 3. The two halves are swapped independently.
- R8: Code 10 puts operand byte 0 in result bits [15:8] and operand byte 1 in bits [7:0]. It then copies result bit 15 into bits [31:16].
- R9: Codes 11 to 15 return the operand unchanged.
- R10: The result is registered. The inputs sampled at a rising clock edge appear on `result_o` after that edge. A clock edge with `rst_n` low sets `result_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| lane_i | input | 2 | Byte-lane offset for the load codes |
| data_i | input | 32 | Fetched word or register operand |
| result_o | output | 32 | Registered writeback value |

## Verification
The assertions compare each result with the operation code and operand of the cycle before. They take for granted that the inputs are stable around every rising clock edge. They also take for granted that the cycle before was already out of reset. The checker tracks that second condition with its own flag, so the first result after reset is not judged against pre-reset inputs. The stimulus changes the inputs only on falling edges and holds them for a full cycle. It also covers the offsets that do not matter for an operation, such as odd halfword offsets and nonzero offsets on register extends. Those cases show the result depends only on the fields the operation uses.

// File: rtl/ldx_pkg.sv
// Package: shared constants and operation codes for the load extend / byte
// swap unit. Assumes byte-addressed little-endian data.
package ldx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        OP_LD_UB  = 4'd0,
        OP_LD_SB  = 4'd1,
        OP_LD_UH  = 4'd2,
        OP_LD_SH  = 4'd3,
        OP_EX_UB  = 4'd4,
        OP_EX_SB  = 4'd5,
        OP_EX_UH  = 4'd6,
        OP_EX_SH  = 4'd7,
        OP_SWAP   = 4'd8,
        OP_SWAP16 = 4'd9,
        OP_SWAPSH = 4'd10
    } ldx_op_e;
endpackage

// File: rtl/ldx_lane_sel.sv
// Module: ldx_lane_sel
// Picks one byte and one halfword out of a word by byte offset.
// Assumes little-endian lanes; the halfword index drops offset bit 0.
module ldx_lane_sel
    import ldx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]              data_i,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0] lane_i,
    output logic [BYTE_W-1:0]              byte_o,
    output logic [2*BYTE_W-1:0]            half_o
);
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int NHALF  = NBYTES / 2;
    localparam int HALF_W = 2 * BYTE_W;
    localparam int LANE_W = $clog2(NBYTES);

    logic [BYTE_W-1:0] lanes  [NBYTES];
    logic [HALF_W-1:0] halves [NHALF];

    // Split the word into byte lanes and halfword lanes.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign lanes[g] = data_i[g*BYTE_W +: BYTE_W];
    end
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign halves[h] = data_i[h*HALF_W +: HALF_W];
    end

    // Index the lanes; halfword ignores the low offset bit.
    assign byte_o = lanes[lane_i];
    assign half_o = halves[lane_i[LANE_W-1:1]];
endmodule

// File: rtl/ldx_extend.sv
// Module: ldx_extend
// Widens a byte or halfword to the full word, zero- or sign-padded.
// Assumes the byte value sits in the low bits of val_i.
module ldx_extend
    import ldx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2*BYTE_W-1:0] val_i,
    input  logic                is_half_i,
    input  logic                is_signed_i,
    output logic [DATA_W-1:0]   ext_o
);
    localparam int HALF_W = 2 * BYTE_W;

    logic fill_b;
    logic fill_h;

    // Fill bit is the top bit of the narrow value when signed, else zero.
    assign fill_b = is_signed_i & val_i[BYTE_W-1];
    assign fill_h = is_signed_i & val_i[HALF_W-1];

    // Concatenate the fill with the narrow value.
    always_comb begin
        if (is_half_i) begin
            ext_o = {{(DATA_W-HALF_W){fill_h}}, val_i};
        end else begin
            ext_o = {{(DATA_W-BYTE_W){fill_b}}, val_i[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/ldx_byte_rev.sv
// Module: ldx_byte_rev
// Produces three byte-swap patterns of a word at once: full swap, swap within
// each halfword, and low-halfword swap with sign extension.
// Assumes DATA_W is a multiple of 16.
module ldx_byte_rev
    import ldx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] swap_o,
    output logic [DATA_W-1:0] swap16_o,
    output logic [DATA_W-1:0] swapsh_o
);
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam int HALF_W = 2 * BYTE_W;

    logic [HALF_W-1:0] low_sw;

    // Full swap: byte i takes byte NBYTES-1-i.
    for (genvar i = 0; i < NBYTES; i++) begin : g_full
        assign swap_o[i*BYTE_W +: BYTE_W] = data_i[(NBYTES-1-i)*BYTE_W +: BYTE_W];
    end

    // Pairwise swap: byte i takes its partner within the same halfword.
    for (genvar i = 0; i < NBYTES; i++) begin : g_pair
        localparam int PARTNER = (i / 2) * 2 + (1 - (i % 2));
        assign swap16_o[i*BYTE_W +: BYTE_W] = data_i[PARTNER*BYTE_W +: BYTE_W];
    end

    // Low-half swap followed by sign extension of bit 15.
    assign low_sw   = {data_i[BYTE_W-1:0], data_i[HALF_W-1:BYTE_W]};
    assign swapsh_o = {{(DATA_W-HALF_W){low_sw[HALF_W-1]}}, low_sw};
endmodule

// File: rtl/ldx_unit.sv
// Module: ldx_unit (top)
// Writeback formatter for narrow loads and register extend / byte swaps.
// Assumes op codes per ldx_pkg; unused codes pass the operand through.
// Result is registered with a synchronous active-low reset.
module ldx_unit
    import ldx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           op_i,
    input  logic [1:0]           lane_i,
    input  logic [DATA_W-1:0]    data_i,
    output logic [DATA_W-1:0]    result_o
);
    localparam int HALF_W = 2 * BYTE_W;

    ldx_op_e           op;
    logic [BYTE_W-1:0] sel_byte;
    logic [HALF_W-1:0] sel_half;
    logic [HALF_W-1:0] narrow;
    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] swap_v;
    logic [DATA_W-1:0] swap16_v;
    logic [DATA_W-1:0] swapsh_v;
    logic [DATA_W-1:0] next_res;
    logic              is_ext_grp;
    logic              is_reg_src;

    assign op = ldx_op_e'(op_i);

    ldx_lane_sel #(.DATA_W(DATA_W)) u_sel (
        .data_i (data_i),
        .lane_i (lane_i),
        .byte_o (sel_byte),
        .half_o (sel_half)
    );

    ldx_byte_rev #(.DATA_W(DATA_W)) u_rev (
        .data_i   (data_i),
        .swap_o   (swap_v),
        .swap16_o (swap16_v),
        .swapsh_o (swapsh_v)
    );

    // Extend group is codes 0..7; bit 2 picks register source over lane pick.
    assign is_ext_grp = ~op_i[3];
    assign is_reg_src = op_i[2];

    // Choose the narrow value: lane-selected for loads, low bits for extends.
    always_comb begin
        if (is_reg_src) begin
            narrow = op_i[1] ? data_i[HALF_W-1:0] : {{BYTE_W{1'b0}}, data_i[BYTE_W-1:0]};
        end else begin
            narrow = op_i[1] ? sel_half : {{BYTE_W{1'b0}}, sel_byte};
        end
    end

    ldx_extend #(.DATA_W(DATA_W)) u_ext (
        .val_i       (narrow),
        .is_half_i   (op_i[1]),
        .is_signed_i (op_i[0]),
        .ext_o       (ext_val)
    );

    // Final result select by operation code.
    always_comb begin
        if (is_ext_grp) begin
            next_res = ext_val;
        end else begin
            case (op)
                OP_SWAP:   next_res = swap_v;
                OP_SWAP16: next_res = swap16_v;
                OP_SWAPSH: next_res = swapsh_v;
                default:   next_res = data_i;
            endcase
        end
    end

    // Result register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
        end else begin
            result_o <= next_res;
        end
    end
endmodule

// File: rtl/ldx_unit_chk.sv
// Module: ldx_unit_chk
// Property checker for ldx_unit, bound to the top module.
// Assumes inputs are stable around each rising edge.
module ldx_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_i,
    input logic [31:0] data_i,
    input logic [31:0] result_o
);
    logic armed;
    logic was_rst;

    // armed: previous edge was out of reset, so $past inputs are meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // was_rst: previous edge saw reset low.
    always_ff @(posedge clk) begin
        was_rst <= ~rst_n;
    end

    AST_UNSIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_i) inside {4'd0, 4'd4}) |-> result_o[31:8] == 24'd0); // R1

    AST_UNSIGNED_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_i) inside {4'd2, 4'd6}) |-> result_o[31:16] == 16'd0); // R1

    AST_SIGNED_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_i) inside {4'd1, 4'd5}) |->
        ($countones(result_o[31:7]) == 0 || $countones(result_o[31:7]) == 25)); // R2

    AST_SIGNED_HALF_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        armed && ($past(op_i) inside {4'd3, 4'd7}) |->
        ($countones(result_o[31:15]) == 0 || $countones(result_o[31:15]) == 17)); // R2

    AST_SWAP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_i) == 4'd8 |-> $countones(result_o) == $countones($past(data_i))); // R6

    AST_SWAP16_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_i) == 4'd9 |->
        $countones(result_o[15:0]) == $countones($past(data_i[15:0]))); // R7

    AST_SWAPSH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_i) == 4'd10 |->
        ($countones(result_o[31:15]) == 0 || $countones(result_o[31:15]) == 17)); // R8

    AST_PASS_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(op_i) > 4'd10 |-> result_o == $past(data_i)); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> result_o == 32'd0); // R10
endmodule

bind ldx_unit ldx_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .data_i   (data_i),
    .result_o (result_o)
);

// File: tb/sim_ldx_unit.sv
// Bench: directed tests for ldx_unit, one task per scenario.
module sim_ldx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [1:0]  lane_i = 2'd0;
    logic [31:0] data_i = 32'd0;
    logic [31:0] result_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    ldx_unit u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .lane_i   (lane_i),
        .data_i   (data_i),
        .result_o (result_o)
    );

    always #5 clk = ~clk;

    // Reference model from the requirements.
    function automatic logic [31:0] ref_model(input logic [3:0] op, input logic [1:0] lane,
                                              input logic [31:0] d);
        logic [7:0]  b;
        logic [15:0] h;
        logic [15:0] sw;
        if (op <= 4'd7) begin
            if (op >= 4'd4) begin
                b = d[7:0];
                h = d[15:0];
            end else begin
                b = d[8*lane +: 8];
                h = lane[1] ? d[31:16] : d[15:0];
            end
            case (op & 4'd3)
                4'd0: return {24'h0, b};
                4'd1: return {{24{b[7]}}, b};
                4'd2: return {16'h0, h};
                default: return {{16{h[15]}}, h};
            endcase
        end
        if (op == 4'd8)  return {d[7:0], d[15:8], d[23:16], d[31:24]};
        if (op == 4'd9)  return {d[23:16], d[31:24], d[7:0], d[15:8]};
        if (op == 4'd10) begin
            sw = {d[7:0], d[15:8]};
            return {{16{sw[15]}}, sw};
        end
        return d;
    endfunction

    task automatic compare(input string req, input logic [31:0] exp);
        total++;
        if (result_o !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, result_o, exp);
        end
    endtask

    // Drive one operation and check it one clock later against the model.
    task automatic run_op(input string req, input logic [3:0] op, input logic [1:0] lane,
                          input logic [31:0] d);
        @(negedge clk);
        op_i = op; lane_i = lane; data_i = d;
        @(negedge clk);
        compare(req, ref_model(op, lane, d));
    endtask

    // Drive one operation and check against a literal expectation.
    task automatic run_lit(input string req, input logic [3:0] op, input logic [1:0] lane,
                           input logic [31:0] d, input logic [31:0] exp);
        @(negedge clk);
        op_i = op; lane_i = lane; data_i = d;
        @(negedge clk);
        compare(req, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        op_i = 4'd15; data_i = 32'hDEAD_BEEF; rst_n = 1'b0;
        @(negedge clk);
        compare("R10 reset clear", 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_unsigned_loads();
        run_lit("R1 byte 0x80 zero pad", 4'd0, 2'd0, 32'h1234_5680, 32'h0000_0080);
        for (int l = 0; l < 4; l++) run_op("R3 unsigned byte lane", 4'd0, l[1:0], 32'hF1E2_D3C4);
        run_op("R3 unsigned half low", 4'd2, 2'd0, 32'h8765_9ABC);
        run_op("R3 unsigned half high", 4'd2, 2'd2, 32'h8765_9ABC);
    endtask

    task automatic t_signed_loads();
        run_lit("R2 byte 0x80 sign fill", 4'd1, 2'd0, 32'h0000_0080, 32'hFFFF_FF80);
        for (int l = 0; l < 4; l++) run_op("R2 signed byte lane", 4'd1, l[1:0], 32'h7F80_01FE);
        run_lit("R3 signed half high", 4'd3, 2'd2, 32'h8001_0000, 32'hFFFF_8001);
        run_op("R2 signed half positive", 4'd3, 2'd0, 32'hFFFF_7FFF);
    endtask

    task automatic t_half_odd();
        run_lit("R4 half offset 1", 4'd2, 2'd1, 32'hAABB_CCDD, 32'h0000_CCDD);
        run_lit("R4 half offset 3", 4'd3, 2'd3, 32'hAABB_CCDD, 32'hFFFF_AABB);
    endtask

    task automatic t_reg_extend();
        run_lit("R5 ext ub lane ignored", 4'd4, 2'd3, 32'h8899_AA80, 32'h0000_0080);
        run_lit("R5 ext sb lane ignored", 4'd5, 2'd2, 32'h0011_2280, 32'hFFFF_FF80);
        run_lit("R5 ext uh lane ignored", 4'd6, 2'd2, 32'h1234_F00D, 32'h0000_F00D);
        run_lit("R5 ext sh lane ignored", 4'd7, 2'd1, 32'h1234_F00D, 32'hFFFF_F00D);
    endtask

    task automatic t_swaps();
        run_lit("R6 full swap", 4'd8, 2'd0, 32'h1122_3344, 32'h4433_2211);
        run_op("R6 full swap pattern", 4'd8, 2'd3, 32'h80FF_0001);
        run_lit("R7 halves swap", 4'd9, 2'd0, 32'h1122_3344, 32'h2211_4433);
        run_lit("R8 signed swap neg", 4'd10, 2'd0, 32'h1234_5680, 32'hFFFF_8056);
        run_lit("R8 signed swap pos", 4'd10, 2'd0, 32'hFFFF_7F00, 32'h0000_007F);
    endtask

    task automatic t_passthrough();
        for (int o = 11; o < 16; o++) run_op("R9 unused code pass", o[3:0], 2'd1, 32'hCAFE_0123 ^ o);
    endtask

    task automatic t_back_to_back();
        // R10: each cycle's result follows the previous cycle's inputs.
        @(negedge clk);
        op_i = 4'd8; data_i = 32'hA1B2_C3D4;
        @(negedge clk);
        compare("R10 first of pair", 32'hD4C3_B2A1);
        op_i = 4'd1; lane_i = 2'd3; data_i = 32'h9000_0000;
        @(negedge clk);
        compare("R10 second of pair", 32'hFFFF_FF90);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_unsigned_loads();
        t_signed_loads();
        t_half_odd();
        t_reg_extend();
        t_swaps();
        t_passthrough();
        t_back_to_back();
        t_reset();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        finish_run();
    end
endmodule